// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an 8192 x 8 asynchronous static RAM. The host hands it one word-sized read or write at a time over a valid/ready request port. The controller turns each request into a timed sequence of chip-select, output-enable and write-enable levels, drives the 13-bit address, and owns the enable of an external tri-state driver on the shared data bus. Read data is sampled once the access time has elapsed and is returned with a single-cycle valid pulse.

The RAM is selected only while its active-low enable is low and its active-high enable is high. The controller parks both enables in the deselecting position whenever it is idle. Every timing window of the RAM is a picosecond parameter, and the controller turns it into a whole number of clock cycles at elaboration. With the defaults (100 MHz clock, 10 ns grade) a read holds the RAM for two cycles. A write has one setup cycle, a one-cycle write pulse and one recovery cycle. A write that follows a read waits one extra turnaround cycle before the driver turns on.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: While reset is held, and in every idle cycle, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dout_en`=0 and `rsp_valid`=0.
- R2: `req_ready` is 1 exactly when the controller is idle. A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1, and `req_write`=1 selects a write.
- R3: A read taken at edge k shows the RAM selected with `mem_oe_n`=0 and `mem_we_n`=1 from edge k for RD_CYC cycles (2 by default), with a constant address. `rsp_valid` is 1 in the cycle after edge k+RD_CYC.
- R4: `rsp_rdata` equals the byte most recently written to that address, or 0 for an address never written.
- R5: A write taken at edge k, with no read before it, drives the bus with the RAM selected and `mem_oe_n`=1 for WS_CYC setup cycles (1 by default). `mem_we_n` is then 0 for exactly WP_CYC cycles (1 by default), starting in the cycle after edge k+WS_CYC.
- R6: Throughout the write pulse, `mem_addr` and `mem_dout` hold the address and data taken with the request.
- R7: The controller never enables its driver while the RAM drives the bus (selected, `mem_oe_n`=0, `mem_we_n`=1), nor in the cycle after it did.
- R8: A write whose preceding operation was a read spends TURN_CYC extra cycles (1 by default) deselected with the driver off before its setup begins, so its pulse starts TURN_CYC cycles later than in R5.
- R9: Each read yields exactly one `rsp_valid` pulse of one cycle, and writes yield none.
- R10: In the cycle after the write pulse ends, `mem_dout_en`=0 and the RAM is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 13 | RAM address |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dout | output | 8 | Data toward the bus driver |
| mem_dout_en | output | 1 | Bus driver enable |
| mem_din | input | 8 | Data sampled from the bus |

## Verification
The hardest situation to reach is a write that arrives right after a read, while the RAM's outputs may still be switching off. Gaps between requests hide that window. To close the gaps, the bench raises `req_valid` for the next operation at the first falling edge after an acceptance. This keeps the controller under constant pressure and walks through read-to-write, write-to-write and write-to-read orders, in fixed and randomized mixes. The bench's RAM model returns a filler byte until a read has been selected for the full access window, and it flags any overlap of the two bus drivers. A capture that is too early, or a turnaround that is dropped, therefore shows up as a data or latency failure at the ports.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RD_SETUP   = 3'd1,
      ST_RD_WAIT    = 3'd2,
      ST_RD_CAPTURE = 3'd3,
      ST_WR_SETUP   = 3'd4,
      ST_WR_PULSE   = 3'd5,
      ST_WR_RECOVER = 3'd6,
      ST_TURN       = 3'd7
   } ctl_state_e;

   // internal strobes, all active high
   typedef struct packed {
      logic sel;
      logic oe;
      logic we;
      logic drive;
   } strobe_t;

   function automatic strobe_t strobe_of(ctl_state_e s);
      strobe_t r;
      r = '0;
      case (s)
         ST_RD_SETUP, ST_RD_WAIT: begin
            r.sel = 1'b1;
            r.oe  = 1'b1;
         end
         ST_WR_SETUP: begin
            r.sel   = 1'b1;
            r.drive = 1'b1;
         end
         ST_WR_PULSE: begin
            r.sel   = 1'b1;
            r.we    = 1'b1;
            r.drive = 1'b1;
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic int cyc_ceil(int ps, int clk_ps);
      return (ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
   import sram_cyc_pkg::*;
#(
   parameter int RD_CYC   = 2,
   parameter int WS_CYC   = 1,
   parameter int WP_CYC   = 1,
   parameter int TURN_CYC = 1,
   parameter int CNT_W    = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             timer_done,
   output logic             req_ready,
   output logic             accept,
   output ctl_state_e       state_q,
   output ctl_state_e       state_d,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val
);

   localparam logic [CNT_W-1:0] LV_RD   = CNT_W'(RD_CYC - 2);
   localparam logic [CNT_W-1:0] LV_WS   = CNT_W'(WS_CYC - 1);
   localparam logic [CNT_W-1:0] LV_WP   = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] LV_TURN = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

   logic       last_rd_q;
   ctl_state_e wr_entry;

   generate
      if (TURN_CYC > 0) begin : g_turn
         assign wr_entry = last_rd_q ? ST_TURN : ST_WR_SETUP;
      end else begin : g_no_turn
         assign wr_entry = ST_WR_SETUP;
      end
   endgenerate

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:       if (req_valid) state_d = req_write ? wr_entry : ST_RD_SETUP;
         ST_RD_SETUP:   state_d = ST_RD_WAIT;
         ST_RD_WAIT:    if (timer_done) state_d = ST_RD_CAPTURE;
         ST_RD_CAPTURE: state_d = ST_IDLE;
         ST_TURN:       if (timer_done) state_d = ST_WR_SETUP;
         ST_WR_SETUP:   if (timer_done) state_d = ST_WR_PULSE;
         ST_WR_PULSE:   if (timer_done) state_d = ST_WR_RECOVER;
         ST_WR_RECOVER: state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   assign timer_load = (state_d != state_q);

   always_comb begin
      case (state_d)
         ST_RD_WAIT:  timer_val = LV_RD;
         ST_TURN:     timer_val = LV_TURN;
         ST_WR_SETUP: timer_val = LV_WS;
         ST_WR_PULSE: timer_val = LV_WP;
         default:     timer_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RD_CAPTURE)
            last_rd_q <= 1'b1;
         else if (accept && req_write)
            last_rd_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sram_cyc_iob.sv
module sram_cyc_iob
   import sram_cyc_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  ctl_state_e        state_q,
   input  ctl_state_e        state_d,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_din,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en
);

   strobe_t nxt;
   logic    capture;

   assign nxt     = strobe_of(state_d);
   assign capture = (state_d == ST_RD_CAPTURE) && (state_q != ST_RD_CAPTURE);

   // strobes registered from the next state: clean edges, aligned with state_q
   always_ff @(posedge clk) begin
      if (rst) begin
         mem_ce_n    <= 1'b1;
         mem_ce      <= 1'b0;
         mem_oe_n    <= 1'b1;
         mem_we_n    <= 1'b1;
         mem_dout_en <= 1'b0;
      end else begin
         mem_ce_n    <= ~nxt.sel;
         mem_ce      <= nxt.sel;
         mem_oe_n    <= ~nxt.oe;
         mem_we_n    <= ~nxt.we;
         mem_dout_en <= nxt.drive;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_addr  <= '0;
         mem_dout  <= '0;
         rsp_rdata <= '0;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
         end
         if (capture)
            rsp_rdata <= mem_din;
      end
   end

   assign rsp_valid = (state_q == ST_RD_CAPTURE);

endmodule

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl
   import sram_cyc_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter int CLK_PS    = 10000,
   parameter int T_AA_PS   = 10000,
   parameter int T_CAP_PS  = 5000,
   parameter int T_WP_PS   = 8000,
   parameter int T_WC_PS   = 10000,
   parameter int T_DW_PS   = 7000,
   parameter int T_HZ_PS   = 6000,
   parameter int WS_MIN    = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din
);

   localparam int RD_CYC   = imax(2, cyc_ceil(T_AA_PS + T_CAP_PS, CLK_PS));
   localparam int WP_CYC   = imax(1, cyc_ceil(T_WP_PS, CLK_PS));
   localparam int WS_CYC   = imax(WS_MIN, cyc_ceil(T_DW_PS, CLK_PS) - WP_CYC);
   localparam int TURN_CYC = cyc_ceil(T_HZ_PS, CLK_PS);
   localparam int MAX_CYC  = imax(imax(RD_CYC, WS_CYC), imax(WP_CYC, TURN_CYC));
   localparam int CNT_W    = imax(1, $clog2(MAX_CYC + 1));

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_cyc_ctrl: address and data widths must be positive");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("sram_cyc_ctrl: clock period must be positive");
      end
      if (WS_MIN < 1) begin : g_bad_ws
         $error("sram_cyc_ctrl: at least one write setup cycle is required");
      end
      if ((WS_CYC + WP_CYC) * CLK_PS < T_WC_PS) begin : g_bad_wc
         $error("sram_cyc_ctrl: write sequence shorter than the cycle time");
      end
   endgenerate

   ctl_state_e       state_q;
   ctl_state_e       state_d;
   logic             accept;
   logic             timer_load;
   logic             timer_done;
   logic [CNT_W-1:0] timer_val;

   sram_cyc_fsm #(
      .RD_CYC   (RD_CYC),
      .WS_CYC   (WS_CYC),
      .WP_CYC   (WP_CYC),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .timer_done (timer_done),
      .req_ready  (req_ready),
      .accept     (accept),
      .state_q    (state_q),
      .state_d    (state_d),
      .timer_load (timer_load),
      .timer_val  (timer_val)
   );

   sram_cyc_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (timer_load),
      .load_val (timer_val),
      .done     (timer_done)
   );

   sram_cyc_iob #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_iob (
      .clk         (clk),
      .rst         (rst),
      .state_q     (state_q),
      .state_d     (state_d),
      .accept      (accept),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .mem_din     (mem_din),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .mem_addr    (mem_addr),
      .mem_ce_n    (mem_ce_n),
      .mem_ce      (mem_ce),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .mem_dout    (mem_dout),
      .mem_dout_en (mem_dout_en)
   );

endmodule

// File: rtl/sram_cyc_ctrl_chk.sv
module sram_cyc_ctrl_chk #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_ce,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dout_en
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dout_en && !rsp_valid));

   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
      (!mem_ce_n || mem_dout_en || rsp_valid) |-> !req_ready);

   p_read_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

   p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(rsp_valid) |-> $past(!mem_oe_n && !mem_ce_n && mem_ce));

   p_we_setup_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_we_n) |-> ($past(mem_dout_en) && $past(!mem_ce_n) && mem_oe_n));

   p_pulse_stable_r6: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dout_en));

   p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
      mem_dout_en |-> (mem_oe_n && !$past(!mem_oe_n)));

   p_single_rsp_r9: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);

   p_release_after_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (!mem_dout_en && mem_ce_n && !mem_ce));

endmodule

bind sram_cyc_ctrl sram_cyc_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .mem_addr    (mem_addr),
   .mem_ce_n    (mem_ce_n),
   .mem_ce      (mem_ce),
   .mem_oe_n    (mem_oe_n),
   .mem_we_n    (mem_we_n),
   .mem_dout    (mem_dout),
   .mem_dout_en (mem_dout_en)
);

// File: tb/sram_cyc_ctrl_tb.sv
module sram_cyc_ctrl_tb;

   localparam int RD  = 2;   // read window, cycles
   localparam int WS  = 1;   // write setup, cycles
   localparam int WP  = 1;   // write pulse, cycles
   localparam int TRN = 1;   // turnaround after a read, cycles
   localparam logic [7:0] FILLER = 8'hEE;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [12:0] mem_addr;
   logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n;
   logic [7:0]  mem_dout;
   logic        mem_dout_en;
   logic [7:0]  mem_din = FILLER;

   always #5 clk = ~clk;

   sram_cyc_ctrl u_dut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
   );

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   bit done_flag = 1'b0;

   logic [7:0] model_mem [int];
   logic [7:0] ref_mem   [int];
   logic [7:0] exp_q     [$];

   int          acc_cyc = 0;
   bit          acc_turn = 1'b0;
   logic [12:0] acc_addr = '0;
   logic [7:0]  acc_data = '0;
   bit          last_was_read = 1'b0;
   int          reads_issued = 0;
   int          rsp_count = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // cycle-level RAM model and port monitor, evaluated between clock edges
   logic        prev_drv = 1'b0;
   logic [12:0] prev_addr = '0;
   int          rd_age = 0;
   int          wp_len = 0;
   logic [12:0] w_addr = '0;
   logic [7:0]  w_data = '0;

   always @(negedge clk) begin
      logic sel, ram_drv;
      logic [7:0] exp_b;
      if (!rst) begin
         sel     = !mem_ce_n && mem_ce;
         ram_drv = sel && !mem_oe_n && mem_we_n;

         if (ram_drv && mem_dout_en)
            check(1'b0, "R7 both sides drive", 1, 0);
         if (prev_drv && mem_dout_en)
            check(1'b0, "R7 driver on inside high-Z window", 1, 0);
         if (req_ready && (sel || !mem_oe_n || !mem_we_n || mem_dout_en || rsp_valid))
            check(1'b0, "R1 idle strobes", {sel, mem_oe_n, mem_we_n, mem_dout_en}, 4'b0110);

         // read access: data only after RD full cycles of a steady selection
         if (ram_drv && prev_drv && mem_addr == prev_addr) rd_age = rd_age + 1;
         else if (ram_drv) rd_age = 1;
         else rd_age = 0;
         if (rd_age >= RD)
            mem_din <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
         else
            mem_din <= FILLER;

         // write pulse tracking
         if (sel && !mem_we_n) begin
            if (wp_len == 0) begin
               check(cyc == acc_cyc + WS + (acc_turn ? TRN : 0),
                     acc_turn ? "R8 pulse start after read" : "R5 pulse start",
                     cyc - acc_cyc, WS + (acc_turn ? TRN : 0));
               check(mem_oe_n && mem_dout_en, "R5 oe high and driver on", {mem_oe_n, mem_dout_en}, 2'b11);
            end else if (mem_addr != w_addr || mem_dout != w_data) begin
               check(1'b0, "R6 address/data moved in pulse", mem_dout, w_data);
            end
            w_addr = mem_addr;
            w_data = mem_dout;
            wp_len = wp_len + 1;
         end else if (wp_len > 0) begin
            check(wp_len == WP, "R5 pulse width", wp_len, WP);
            check(w_addr == acc_addr && w_data == acc_data, "R6 pulse address/data",
                  {w_addr, w_data}, {acc_addr, acc_data});
            check(!mem_dout_en && !sel, "R10 release after pulse", {mem_dout_en, sel}, 0);
            model_mem[int'(w_addr)] = w_data;
            wp_len = 0;
         end

         if (rsp_valid) begin
            rsp_count++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 response without read", 1, 0);
            end else begin
               exp_b = exp_q.pop_front();
               check(rsp_rdata == exp_b, "R4 read data", rsp_rdata, exp_b);
               check(cyc == acc_cyc + RD, "R3 read latency", cyc - acc_cyc, RD);
            end
         end

         prev_drv  = ram_drv;
         prev_addr = mem_addr;
      end
   end

   task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      acc_cyc  = cyc;
      acc_turn = wr && last_was_read;
      acc_addr = a;
      acc_data = d;
      last_was_read = !wr;
      if (wr) begin
         ref_mem[int'(a)] = d;
      end else begin
         exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
         reads_issued++;
      end
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: values held during reset
      check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dout_en && !rsp_valid,
            "R1 reset strobes", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_en, rsp_valid}, 6'b101100);
      check(req_ready == 1'b1, "R2 ready in idle after reset", req_ready, 1);
      rst = 1'b0;

      // R2: busy controller drops ready; check one cycle after a taken read
      issue(1'b0, 13'h0123, 8'h00);          // unwritten address reads 0 (R4)
      @(negedge clk);
      check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      wait_idle();

      issue(1'b1, 13'h0000, 8'h5A);          // write, no read before... (last op was a read: R8)
      issue(1'b1, 13'h1FFF, 8'hA5);          // write after write (R5)
      issue(1'b0, 13'h0000, 8'h00);          // write then read (R4)
      issue(1'b0, 13'h1FFF, 8'h00);          // top address (R4)
      issue(1'b1, 13'h0042, 8'hC3);          // read then write (R8)
      issue(1'b1, 13'h0042, 8'h3C);          // overwrite (R4)
      issue(1'b0, 13'h0042, 8'h00);
      issue(1'b0, 13'h0042, 8'h00);          // read after read
      wait_idle();

      // mixed back-to-back traffic on a small address set
      for (int i = 0; i < 300; i++) begin
         logic [12:0] a;
         a = 13'($urandom_range(0, 15)) | ((i % 3 == 0) ? 13'h1FF0 : 13'h0000);
         issue(1'($urandom_range(0, 1)), a, 8'($urandom));
      end
      wait_idle();

      check(rsp_count == reads_issued, "R9 one response per read", rsp_count, reads_issued);
      check(exp_q.size() == 0, "R9 no read left unanswered", exp_q.size(), 0);
      check(req_ready && mem_ce_n && !mem_ce, "R1 idle at end", {req_ready, mem_ce_n, mem_ce}, 3'b110);
      finish_up();
   end

endmodule